// File: doc/BRIEF.md
# Indirect Analog Control Register Bridge

This block puts a bank of small 8-bit control registers behind one 32-bit host register. The host never addresses the bank directly. It writes a configuration word that carries a bank reset-release bit, a direction bit, a 5-bit internal index and a data byte. It then reads the same word back and finds the selected bank byte in its low eight bits. A write to the bank is a short sequence of host writes. First the index and data are placed in the word with the direction bit low. Then the direction bit is raised, and then it is lowered again.

The bank powers up cleared and stays cleared until the host sets the reset-release bit. Every byte of the bank is also driven on a flat parallel output, so downstream enable and gain logic can use the settings without going through the host port. Reads have one clock of latency. Host addresses other than the configuration offset read as zero and ignore writes.

Top module: `indirect_ctl_bridge`

## Requirements
- R1: After `rst_n` is low at a clock edge, `hst_rdata` reads 0 and every byte of `bank_flat` is 0x00.
- R2: While the stored bit 28 of the configuration word is 0, all bank bytes are cleared to 0x00 and no bank write takes effect. This includes a write that raises bit 28 and bit 24 together.
- R3: A host write to the configuration word commits bits 15:8 into the bank byte selected by bits 20:16 of that same write when three conditions hold: the stored bit 28 is 1, the written bit 28 is 1, and the written bit 24 is 1 while the stored bit 24 is 0.
- R4: When stored bit 24 is already 1, host writes that keep bit 24 at 1 commit nothing to the bank, whatever data or index they carry.
- R5: Bits 7:0 of a configuration read return the exact stored byte of the bank entry selected by the stored bits 20:16.
- R6: Bits 31:8 of a configuration read return the bits last written there. Bits 7:0 of a host write are ignored.
- R7: `hst_rdata` reflects the state present at the clock edge where `hst_addr` was sampled, so it is due one clock later. A host address other than the configuration offset (0) reads 0, and writes to it change nothing.
- R8: Bank entry i appears on `bank_flat[8*i+7:8*i]`.
- R9: Clearing bit 28 after bank writes has been made clears every bank byte. A later commit needs bit 28 set again, followed by a fresh 0-to-1 transition of bit 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_addr | input | HOST_AW | Host register address; the configuration word is at CFG_OFFSET |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, registered |
| bank_flat | output | 8*NREG | All bank bytes, entry i at bits 8*i+7:8*i |

## Verification
A host write updates the stored configuration fields and any bank commit at the rising edge that samples it. `bank_flat` therefore shows the new byte from that edge on. The read word needs one more edge, because `hst_rdata` registers the state that already includes the write. The bench drives each host word on a falling edge and removes it on the next falling edge. It checks `bank_flat` right after that, and it samples `hst_rdata` one further falling edge later, so every comparison falls inside the cycle where its result is due.

// File: rtl/indirect_ctl_bridge.sv
module indirect_ctl_bridge #(
  parameter int NREG       = 32,
  parameter int HOST_AW    = 4,
  parameter int CFG_OFFSET = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HOST_AW-1:0]  hst_addr,
  input  logic                hst_wr,
  input  logic [31:0]         hst_wdata,
  output logic [31:0]         hst_rdata,
  output logic [8*NREG-1:0]   bank_flat
);

  localparam int AW       = $clog2(NREG);
  localparam int RST_BIT  = 28;
  localparam int DIR_BIT  = 24;
  localparam int IDX_LSB  = 16;
  localparam int WDAT_LSB = 8;

  logic [31:8] cfg_q;
  logic [7:0]  bank [NREG];

  wire           cfg_sel   = (hst_addr == CFG_OFFSET[HOST_AW-1:0]);
  wire           cfg_wr    = hst_wr && cfg_sel;
  wire           bank_live = cfg_q[RST_BIT];
  wire [AW-1:0]  wr_idx    = hst_wdata[IDX_LSB +: AW];
  wire [AW-1:0]  rd_idx    = cfg_q[IDX_LSB +: AW];
  wire [7:0]     wr_byte   = hst_wdata[WDAT_LSB +: 8];
  wire           commit    = cfg_wr && bank_live && hst_wdata[RST_BIT]
                             && hst_wdata[DIR_BIT] && !cfg_q[DIR_BIT];
  wire           unused_low_byte = ^hst_wdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= hst_wdata[31:8];
  end

  for (genvar i = 0; i < NREG; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n || !bank_live)
        bank[i] <= 8'h00;
      else if (commit && (wr_idx == AW'(i)))
        bank[i] <= wr_byte;
    end
    assign bank_flat[8*i +: 8] = bank[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       hst_rdata <= '0;
    else if (cfg_sel) hst_rdata <= {cfg_q, bank[rd_idx]};
    else              hst_rdata <= '0;
  end

endmodule

// File: rtl/indirect_ctl_bridge_chk.sv
module indirect_ctl_bridge_chk #(
  parameter int NREG       = 32,
  parameter int HOST_AW    = 4,
  parameter int CFG_OFFSET = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [HOST_AW-1:0] hst_addr,
  input logic               hst_wr,
  input logic [31:0]        hst_wdata,
  input logic [31:0]        hst_rdata,
  input logic [8*NREG-1:0]  bank_flat,
  input logic [31:8]        cfg_q
);
  localparam int AW = $clog2(NREG);
  wire sel = (hst_addr == CFG_OFFSET[HOST_AW-1:0]);

  p_cleared_while_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[28] |=> bank_flat == '0);

  p_commit_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && sel && cfg_q[28] && hst_wdata[28] && hst_wdata[24] && !cfg_q[24])
    |=> bank_flat[8*$past(hst_wdata[16 +: AW]) +: 8] == $past(hst_wdata[15:8]));

  p_no_commit_without_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[28] && !(hst_wr && sel && hst_wdata[24] && !cfg_q[24])) |=> $stable(bank_flat));

  p_fields_stored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && sel) |=> cfg_q == $past(hst_wdata[31:8]));

  p_other_addr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> hst_rdata == 32'h0);

  p_read_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> hst_rdata[31:8] == $past(cfg_q));
endmodule

bind indirect_ctl_bridge indirect_ctl_bridge_chk #(
  .NREG(NREG), .HOST_AW(HOST_AW), .CFG_OFFSET(CFG_OFFSET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
  .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .bank_flat(bank_flat),
  .cfg_q(cfg_q)
);

// File: tb/sim_indirect_ctl_bridge.sv
`timescale 1ns/1ps
module sim_indirect_ctl_bridge;
  localparam int NREG = 32;
  localparam int HAW  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [HAW-1:0]    hst_addr;
  logic              hst_wr;
  logic [31:0]       hst_wdata;
  logic [31:0]       hst_rdata;
  logic [8*NREG-1:0] bank_flat;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [NREG];

  always #10 clk = ~clk;

  indirect_ctl_bridge #(.NREG(NREG), .HOST_AW(HAW), .CFG_OFFSET(0)) u0 (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .bank_flat(bank_flat)
  );

  function automatic logic [31:0] mk(input logic rst, input logic dir,
                                     input logic [4:0] idx, input logic [7:0] d);
    return {3'b0, rst, 3'b0, dir, 3'b0, idx, d, 8'h00};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic hw(input logic [31:0] w);
    hst_addr = '0; hst_wr = 1'b1; hst_wdata = w;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic sample(output logic [31:0] v);
    @(negedge clk);
    v = hst_rdata;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    hw(mk(1'b1, 1'b0, a, d));
    hw(mk(1'b1, 1'b1, a, d));
    hw(mk(1'b1, 1'b0, a, d));
    model[a] = d;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    logic [31:0] v;
    hw(mk(1'b1, 1'b0, a, 8'h00));
    sample(v);
    d = v[7:0];
  endtask

  function automatic logic [8*NREG-1:0] model_flat();
    logic [8*NREG-1:0] f;
    for (int i = 0; i < NREG; i++) f[8*i +: 8] = model[i];
    return f;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  b;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    rst_n = 1'b0; hst_addr = '0; hst_wr = 1'b0; hst_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 rdata", {32'h0, hst_rdata}, 64'h0);
    check("R1 bank", {32'h0, bank_flat[31:0]}, 64'h0);
    check("R1 bank all", {63'h0, bank_flat == '0}, 64'h1);
    rst_n = 1'b1;

    hw(mk(1'b1, 1'b0, 5'd0, 8'h00));

    for (int a = 0; a < NREG; a++) wr_reg(5'(a), 8'((a * 37 + 11) & 8'hff));
    check("R8 flat after sweep", {63'h0, bank_flat == model_flat()}, 64'h1);
    for (int a = 0; a < NREG; a++) begin
      check("R8 entry", {56'h0, bank_flat[8*a +: 8]}, {56'h0, model[a]});
      rd_reg(5'(a), b);
      check("R5 readback", {56'h0, b}, {56'h0, model[a]});
    end

    // R3/R5 read-modify-write sets bits 3:2 of entry 0x0A, others kept
    rd_reg(5'h0A, b);
    wr_reg(5'h0A, b | 8'h0C);
    rd_reg(5'h0A, b);
    check("R3 rmw", {56'h0, b}, {56'h0, model[10]});
    check("R3 rmw value", {56'h0, b}, {56'h0, 8'((10 * 37 + 11) & 8'hff) | 8'h0C});

    // R4: holding the direction bit high commits nothing more
    hw(mk(1'b1, 1'b0, 5'd4, 8'h11));
    hw(mk(1'b1, 1'b1, 5'd4, 8'h11));
    model[4] = 8'h11;
    hw(mk(1'b1, 1'b1, 5'd4, 8'h99));
    check("R4 same index", {56'h0, bank_flat[8*4 +: 8]}, 64'h11);
    hw(mk(1'b1, 1'b1, 5'd9, 8'h77));
    check("R4 other index", {56'h0, bank_flat[8*9 +: 8]}, {56'h0, model[9]});
    check("R4 whole bank", {63'h0, bank_flat == model_flat()}, 64'h1);
    hw(mk(1'b1, 1'b0, 5'd9, 8'h77));
    check("R4 drop commits nothing", {63'h0, bank_flat == model_flat()}, 64'h1);

    // R6: fields read back, host low byte ignored; this word also raises bit 24
    hw(32'h1355_AAFF);
    model[5'h15] = 8'hAA;
    sample(v);
    check("R6 readback", {32'h0, v}, {32'h0, 24'h1355AA, 8'hAA});
    check("R3 commit via full word", {56'h0, bank_flat[8*21 +: 8]}, 64'hAA);
    hw(mk(1'b1, 1'b0, 5'h15, 8'h00));

    // R7: other host address
    hst_addr = 4'd3; hst_wr = 1'b1; hst_wdata = mk(1'b0, 1'b1, 5'd2, 8'h55);
    @(negedge clk);
    hst_wr = 1'b0;
    @(negedge clk);
    check("R7 other addr reads zero", {32'h0, hst_rdata}, 64'h0);
    check("R7 other addr write ignored", {63'h0, bank_flat == model_flat()}, 64'h1);
    hst_addr = '0;
    sample(v);
    check("R7 cfg unchanged", {32'h0, v}, {32'h0, mk(1'b1, 1'b0, 5'h15, 8'h00) | {24'h0, model[5'h15]}});

    // R2/R9: clear and hold
    hw(mk(1'b0, 1'b0, 5'd3, 8'h00));
    @(negedge clk);
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    check("R9 cleared", {63'h0, bank_flat == '0}, 64'h1);
    hw(mk(1'b0, 1'b1, 5'd3, 8'h5A));
    @(negedge clk);
    check("R2 write ignored in reset", {63'h0, bank_flat == '0}, 64'h1);
    hw(mk(1'b1, 1'b1, 5'd3, 8'h5A));
    check("R2 no commit without new rise", {63'h0, bank_flat == '0}, 64'h1);
    hw(mk(1'b0, 1'b0, 5'd3, 8'h5A));
    hw(mk(1'b1, 1'b1, 5'd3, 8'h5A));
    check("R2 release and rise together ignored", {63'h0, bank_flat == '0}, 64'h1);
    hw(mk(1'b1, 1'b0, 5'd3, 8'h5A));
    hw(mk(1'b1, 1'b1, 5'd3, 8'h5A));
    check("R9 commit after release", {56'h0, bank_flat[8*3 +: 8]}, 64'h5A);
    rd_reg(5'd3, b);
    check("R5 readback after release", {56'h0, b}, 64'h5A);

    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset mid-run bank", {63'h0, bank_flat == '0}, 64'h1);
    check("R1 reset mid-run rdata", {32'h0, hst_rdata}, 64'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule